// File: doc/BRIEF.md
# Execution ALU Operand Datapath

This block is the operand-selection and result path that sits around one 64-bit adder in a single ALU of an execution core that has several ALUs. The first operand comes from one of nine sources. Five of them are the result buses of the other ALUs, three are register-file read ports, and one is this ALU's own registered result fed straight back. That operand then goes through a small left-shift selector. The second operand reaches the adder either unchanged or bitwise inverted. When it is inverted, the adder carry-in is forced high, so the same adder also performs subtraction.

A final three-way select chooses what is registered as the result. The choices are the adder sum, a bitwise logic result (AND, OR or XOR of the shifted first operand and the possibly inverted second operand), or the shifted first operand passed through unchanged. The result register updates on every rising clock edge. Because the loopback source reads that register, an operation can consume the previous cycle's result with no gap. Any select code outside its defined range makes the next registered result zero.

Top module: `alu_operand_path`

## Requirements
- R1: While `rst_n` is low, `result` is zero. It clears asynchronously, without waiting for a clock edge.
- R2: The first operand is chosen by `src_sel` as follows: code 0 is the block's own `result`, codes 1 to 5 are `peer_bus` slice (code-1), and codes 6 to 8 are `rf_port` slice (code-6). Slice k occupies bits [64k+63:64k].
- R3: `shift_sel` codes 0 to 4 shift the chosen first operand left by that many bit positions, filling with zeros and dropping bits shifted out of the top.
- R4: With `b_inv`=0 the adder computes A+B. With `b_inv`=1 it adds the complement of B with a carry-in of 1, giving A−B. Both results wrap modulo 2^64.
- R5: `logic_op` code 0 gives AND, code 1 gives OR and code 2 gives XOR. The operands are the shifted first operand and the second operand after the optional inversion.
- R6: `res_sel` code 0 registers the adder sum, code 1 the logic result, and code 2 the shifted first operand.
- R7: `result` changes only at a rising clock edge, one cycle after the inputs are applied. A loopback operation (src_sel=0) in consecutive cycles uses each previous result.
- R8: Any of the following makes the next `result` zero: `src_sel` 9 to 15, `shift_sel` 5 to 7, `res_sel` 3, or `logic_op` 3 when `res_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| peer_bus | input | 320 | Result buses of the five other ALUs, packed 64 bits each |
| rf_port | input | 192 | Three register-file read operands, packed 64 bits each |
| src_sel | input | 4 | First-operand source code |
| shift_sel | input | 3 | Left-shift amount code |
| b_operand | input | 64 | Second operand |
| b_inv | input | 1 | Invert second operand and set carry-in |
| res_sel | input | 2 | Result source code |
| logic_op | input | 2 | Bitwise operation code |
| result | output | 64 | Registered ALU result, also the loopback source |

## Verification
The embedded assertions check five properties on every cycle. A pass-through of the loopback source with no shift leaves the result unchanged. Any out-of-range code zeroes the next result. Subtracting an operand from an equal shifted first operand gives zero. An AND result never sets a bit that is clear in the second operand. A four-place shift clears the low four result bits. Only the directed scenarios can show that each source code reaches the right slice, and that sums and differences have exact values, including wrap-around. They also show that consecutive loopback additions accumulate, and that reset clears the register between clock edges.

// File: rtl/alu_dp_pkg.sv
package alu_dp_pkg;

    typedef enum logic [1:0] {
        RES_SUM   = 2'd0,
        RES_LOGIC = 2'd1,
        RES_PASS  = 2'd2,
        RES_BAD   = 2'd3
    } res_sel_e;

    typedef enum logic [1:0] {
        LOP_AND = 2'd0,
        LOP_OR  = 2'd1,
        LOP_XOR = 2'd2,
        LOP_BAD = 2'd3
    } logic_op_e;

endpackage

// File: rtl/operand_a_mux.sv
module operand_a_mux #(
    parameter int W      = 64,
    parameter int N_PEER = 5,
    parameter int N_RF   = 3,
    localparam int N_SRC = 1 + N_PEER + N_RF,
    localparam int SRC_W = $clog2(N_SRC + 1)
) (
    input  logic [W-1:0]        self_val,
    input  logic [N_PEER*W-1:0] peer_bus,
    input  logic [N_RF*W-1:0]   rf_port,
    input  logic [SRC_W-1:0]    sel,
    output logic [W-1:0]        operand,
    output logic                sel_ok
);
    logic [W-1:0] cand [N_SRC];

    assign cand[0] = self_val;

    genvar p;
    generate
        for (p = 0; p < N_PEER; p++) begin : g_peer
            assign cand[1 + p] = peer_bus[p*W +: W];
        end
        for (p = 0; p < N_RF; p++) begin : g_rf
            assign cand[1 + N_PEER + p] = rf_port[p*W +: W];
        end
    endgenerate

    always_comb begin
        sel_ok  = (int'(sel) < N_SRC);
        operand = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (int'(sel) == i) operand = cand[i];
        end
    end
endmodule

// File: rtl/shift_sel_mux.sv
module shift_sel_mux #(
    parameter int W       = 64,
    parameter int N_SHIFT = 5,
    localparam int SH_W   = $clog2(N_SHIFT + 1)
) (
    input  logic [W-1:0]    din,
    input  logic [SH_W-1:0] sel,
    output logic [W-1:0]    dout,
    output logic            sel_ok
);
    logic [W-1:0] cand [N_SHIFT];

    genvar k;
    generate
        for (k = 0; k < N_SHIFT; k++) begin : g_shift
            assign cand[k] = din << k;
        end
    endgenerate

    always_comb begin
        sel_ok = (int'(sel) < N_SHIFT);
        dout   = '0;
        for (int i = 0; i < N_SHIFT; i++) begin
            if (int'(sel) == i) dout = cand[i];
        end
    end
endmodule

// File: rtl/bitwise_unit.sv
module bitwise_unit
    import alu_dp_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   op,
    output logic [W-1:0] y,
    output logic         op_ok
);
    logic_op_e op_e;
    assign op_e = logic_op_e'(op);

    always_comb begin
        y     = '0;
        op_ok = 1'b1;
        unique case (op_e)
            LOP_AND: y = a & b;
            LOP_OR:  y = a | b;
            LOP_XOR: y = a ^ b;
            default: op_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/core_adder.sv
module core_adder #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum
);
    assign sum = a + b + {{(W-1){1'b0}}, cin};
endmodule

// File: rtl/alu_operand_path.sv
module alu_operand_path
    import alu_dp_pkg::*;
#(
    parameter int W       = 64,
    parameter int N_PEER  = 5,
    parameter int N_RF    = 3,
    parameter int N_SHIFT = 5,
    localparam int N_SRC  = 1 + N_PEER + N_RF,
    localparam int SRC_W  = $clog2(N_SRC + 1),
    localparam int SH_W   = $clog2(N_SHIFT + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_PEER*W-1:0] peer_bus,
    input  logic [N_RF*W-1:0]   rf_port,
    input  logic [SRC_W-1:0]    src_sel,
    input  logic [SH_W-1:0]     shift_sel,
    input  logic [W-1:0]        b_operand,
    input  logic                b_inv,
    input  logic [1:0]          res_sel,
    input  logic [1:0]          logic_op,
    output logic [W-1:0]        result
);
    logic [W-1:0] a_raw, a_shift, b_eff, sum, logic_y, next_val;
    logic         src_ok, shift_ok, lop_ok, res_ok, all_ok;
    res_sel_e     res_e;

    operand_a_mux #(.W(W), .N_PEER(N_PEER), .N_RF(N_RF)) u_amux (
        .self_val (result),
        .peer_bus (peer_bus),
        .rf_port  (rf_port),
        .sel      (src_sel),
        .operand  (a_raw),
        .sel_ok   (src_ok)
    );

    shift_sel_mux #(.W(W), .N_SHIFT(N_SHIFT)) u_shift (
        .din    (a_raw),
        .sel    (shift_sel),
        .dout   (a_shift),
        .sel_ok (shift_ok)
    );

    assign b_eff = b_inv ? ~b_operand : b_operand;

    core_adder #(.W(W)) u_add (
        .a   (a_shift),
        .b   (b_eff),
        .cin (b_inv),
        .sum (sum)
    );

    bitwise_unit #(.W(W)) u_logic (
        .a     (a_shift),
        .b     (b_eff),
        .op    (logic_op),
        .y     (logic_y),
        .op_ok (lop_ok)
    );

    assign res_e = res_sel_e'(res_sel);

    always_comb begin
        next_val = '0;
        res_ok   = 1'b1;
        unique case (res_e)
            RES_SUM:   next_val = sum;
            RES_LOGIC: begin
                next_val = logic_y;
                res_ok   = lop_ok;
            end
            RES_PASS:  next_val = a_shift;
            default:   res_ok = 1'b0;
        endcase
    end

    assign all_ok = src_ok && shift_ok && res_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) result <= '0;
        else        result <= all_ok ? next_val : '0;
    end

    // R7: loopback passed through unshifted holds the register
    a_r7_self_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == '0 && shift_sel == '0 && res_sel == 2'd2) |=> (result == $past(result)));

    // R8: undefined source code yields zero
    a_r8_bad_src_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(src_sel) >= N_SRC) |=> (result == '0));

    // R8: undefined result code yields zero
    a_r8_bad_res_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (res_sel == 2'd3) |=> (result == '0));

    // R4: subtracting an operand equal to the shifted first operand gives zero
    a_r4_self_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ok && shift_ok && res_sel == 2'd0 && b_inv && a_shift == b_operand) |=> (result == '0));

    // R5: AND never sets a bit clear in the uninverted second operand
    a_r5_and_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ok && shift_ok && res_sel == 2'd1 && logic_op == 2'd0 && !b_inv)
        |=> ((result & ~$past(b_operand)) == '0));

    // R3: four-place shift leaves low four bits clear on pass-through
    a_r3_low_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ok && int'(shift_sel) == 4 && res_sel == 2'd2) |=> (result[3:0] == 4'h0));
endmodule

// File: tb/alu_operand_path_bench.sv
module alu_operand_path_bench;
    localparam int W = 64;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [5*W-1:0] peer_bus = '0;
    logic [3*W-1:0] rf_port = '0;
    logic [3:0]     src_sel = '0;
    logic [2:0]     shift_sel = '0;
    logic [W-1:0]   b_operand = '0;
    logic           b_inv = 1'b0;
    logic [1:0]     res_sel = '0;
    logic [1:0]     logic_op = '0;
    logic [W-1:0]   result;

    int checks = 0;
    int failures = 0;
    logic [W-1:0] model_q = '0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    alu_operand_path u_alu_operand_path (
        .clk(clk), .rst_n(rst_n), .peer_bus(peer_bus), .rf_port(rf_port),
        .src_sel(src_sel), .shift_sel(shift_sel), .b_operand(b_operand),
        .b_inv(b_inv), .res_sel(res_sel), .logic_op(logic_op), .result(result)
    );

    task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    function automatic logic [W-1:0] model(logic [3:0] s, logic [2:0] sh,
                                           logic [W-1:0] b, logic inv,
                                           logic [1:0] rs, logic [1:0] lop);
        logic [W-1:0] a, bb;
        if (s == 0)      a = model_q;
        else if (s <= 5) a = peer_bus[(s-1)*W +: W];
        else if (s <= 8) a = rf_port[(s-6)*W +: W];
        else return '0;
        if (sh > 4) return '0;
        a  = a << sh;
        bb = inv ? ~b : b;
        case (rs)
            2'd0: return inv ? (a - b) : (a + b);
            2'd1: case (lop)
                      2'd0: return a & bb;
                      2'd1: return a | bb;
                      2'd2: return a ^ bb;
                      default: return '0;
                  endcase
            2'd2: return a;
            default: return '0;
        endcase
    endfunction

    task automatic step(string req, logic [3:0] s, logic [2:0] sh, logic [W-1:0] b,
                        logic inv, logic [1:0] rs, logic [1:0] lop);
        logic [W-1:0] exp;
        @(negedge clk);
        src_sel = s; shift_sel = sh; b_operand = b; b_inv = inv;
        res_sel = rs; logic_op = lop;
        exp = model(s, sh, b, inv, rs, lop);
        #1;
        check("R7 (held until edge)", result, model_q);
        @(posedge clk);
        #1;
        check(req, result, exp);
        model_q = exp;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        #3;
        check("R1", result, '0);
        @(negedge clk);
        rst_n = 1'b1;
        model_q = '0;
    endtask

    task automatic t_src_select();
        for (int k = 0; k < 5; k++) peer_bus[k*W +: W] = 64'h1111_0000_0000_0000 * (k + 1) + 64'(k);
        for (int k = 0; k < 3; k++) rf_port[k*W +: W]  = 64'hA0A0_0000_0000_0000 + 64'(16 * k + 7);
        for (int c = 1; c <= 8; c++) step("R2", 4'(c), 3'd0, '0, 1'b0, 2'd2, 2'd0);
        step("R2 (self)", 4'd0, 3'd0, '0, 1'b0, 2'd2, 2'd0);
    endtask

    task automatic t_shift();
        rf_port[0 +: W] = 64'h8000_0000_0000_000F;
        for (int c = 0; c <= 4; c++) step("R3", 4'd6, 3'(c), '0, 1'b0, 2'd2, 2'd0);
    endtask

    task automatic t_add_sub();
        rf_port[W +: W] = 64'hFFFF_FFFF_FFFF_FFFF;
        step("R4 add wrap", 4'd7, 3'd0, 64'd1, 1'b0, 2'd0, 2'd0);
        rf_port[W +: W] = 64'd10;
        step("R4 sub", 4'd7, 3'd0, 64'd3, 1'b1, 2'd0, 2'd0);
        rf_port[W +: W] = 64'd3;
        step("R4 sub negative", 4'd7, 3'd0, 64'd10, 1'b1, 2'd0, 2'd0);
        step("R4 shifted add", 4'd7, 3'd2, 64'd100, 1'b0, 2'd0, 2'd0);
    endtask

    task automatic t_logic();
        rf_port[2*W +: W] = 64'hF0F0_1234_5678_9ABC;
        step("R5 R6 and", 4'd8, 3'd0, 64'h0FF0_FFFF_0000_FFFF, 1'b0, 2'd1, 2'd0);
        step("R5 R6 or",  4'd8, 3'd0, 64'h0FF0_FFFF_0000_FFFF, 1'b0, 2'd1, 2'd1);
        step("R5 R6 xor", 4'd8, 3'd0, 64'h0FF0_FFFF_0000_FFFF, 1'b0, 2'd1, 2'd2);
        step("R5 and inverted", 4'd8, 3'd1, 64'h0FF0_FFFF_0000_FFFF, 1'b1, 2'd1, 2'd0);
    endtask

    task automatic t_loopback();
        rf_port[0 +: W] = 64'd5;
        step("R7 seed", 4'd6, 3'd0, '0, 1'b0, 2'd2, 2'd0);
        for (int i = 0; i < 3; i++) step("R7 back-to-back", 4'd0, 3'd0, 64'd3, 1'b0, 2'd0, 2'd0);
        step("R7 loop sub", 4'd0, 3'd0, 64'd14, 1'b1, 2'd0, 2'd0);
    endtask

    task automatic t_bad_sel();
        rf_port[0 +: W] = 64'hDEAD_BEEF_0000_0001;
        step("R8 seed", 4'd6, 3'd0, '0, 1'b0, 2'd2, 2'd0);
        step("R8 src 9", 4'd9, 3'd0, 64'd1, 1'b0, 2'd0, 2'd0);
        step("R8 seed", 4'd6, 3'd0, '0, 1'b0, 2'd2, 2'd0);
        step("R8 src 15", 4'd15, 3'd0, 64'd1, 1'b0, 2'd2, 2'd0);
        step("R8 seed", 4'd6, 3'd0, '0, 1'b0, 2'd2, 2'd0);
        step("R8 shift 5", 4'd6, 3'd5, '0, 1'b0, 2'd2, 2'd0);
        step("R8 seed", 4'd6, 3'd0, '0, 1'b0, 2'd2, 2'd0);
        step("R8 shift 7", 4'd6, 3'd7, '0, 1'b0, 2'd0, 2'd0);
        step("R8 seed", 4'd6, 3'd0, '0, 1'b0, 2'd2, 2'd0);
        step("R8 res 3", 4'd6, 3'd0, 64'd9, 1'b0, 2'd3, 2'd0);
        step("R8 seed", 4'd6, 3'd0, '0, 1'b0, 2'd2, 2'd0);
        step("R8 logic op 3", 4'd6, 3'd0, 64'hFF, 1'b0, 2'd1, 2'd3);
        step("R8 op 3 unused", 4'd6, 3'd0, 64'd2, 1'b0, 2'd0, 2'd3);
    endtask

    task automatic t_reset_midrun();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 async clear", result, '0);
        @(negedge clk);
        rst_n = 1'b1;
        model_q = '0;
    endtask

    initial begin
        t_reset();
        t_src_select();
        t_shift();
        t_add_sub();
        t_logic();
        t_loopback();
        t_bad_sel();
        t_reset_midrun();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule